// File: doc/BRIEF.md
# UART register and interrupt controller

This block is the bus-facing register file of a 16550-style serial port. A host reaches eight 32-bit registers through single-cycle word accesses, and the block turns those accesses into transmit byte strobes and configuration outputs. The serial shifter, baud generator, parity checker and any FIFO sit outside the block. It holds one received byte, keeps sticky line-error flags and drives one level interrupt whose cause is reported as a fixed-priority code.

Received bytes enter on a byte port with valid and ready. The ready output is advisory: a byte offered while the holding register is full is still taken. It replaces the held byte and raises the overrun flag. Parity, framing and break events arrive as one-cycle pulses. The two transmitter-empty flags and the eight modem-status bits arrive as levels, and the block samples them into its status registers every cycle.

Top module: `uart_regblk`

## Requirements
- R1: After reset, a read of the line status register (index 5) returns 0x60, a read of the identification register (index 2) returns 0x01, irq is low, rx_ready is high, and line_cfg, modem_cfg, baud_div and tx_strobe are zero.
- R2: The register index is bus_addr[4:2]. A write to index 1 (enable), 3 (line config), 4 (modem config) or 7 (divisor) stores the value. Indices 3, 4 and 7 drive line_cfg, modem_cfg and baud_div from the next cycle. A read of any of these four indices returns zero and raises bus_err.
- R3: A write to index 2, 5 or 6 changes no state and raises bus_err.
- R4: A write to index 0 pulses tx_strobe for one cycle in the next cycle, with tx_byte equal to the low 8 bits of the write data.
- R5: A byte taken on rx_valid sets data-ready (status bit 0) and drops rx_ready. A read of index 0 returns the held byte in bits 7:0 and clears data-ready, unless a new byte arrives in the same cycle.
- R6: A byte that arrives while data-ready is set and index 0 is not being read in that cycle sets overrun (status bit 1) and replaces the held byte. When the byte arrives in the same cycle as a data read, the read returns the old byte, the new byte is held and overrun stays clear.
- R7: Pulses on lerr_parity, lerr_frame and lerr_break set status bits 2, 3 and 4. These bits and overrun hold until a status read, which returns them and then clears them. An event in the same cycle as that read survives it.
- R8: Status bits 5 and 6 follow tx_hold_empty and tx_shift_empty, and a read of index 6 returns modem_stat, each sampled one cycle earlier.
- R9: Enable bits are: bit 2 line error, bit 0 receive data, bit 1 transmit empty, bit 3 modem change. The identification code, from highest to lowest priority, is: 0x06 for an enabled line error (status bits 4:1), 0x04 for enabled data-ready, 0x02 for enabled transmit-holding-empty, and 0x00 for an enabled modem delta (modem bits 3:0). Otherwise it is 0x01 and irq is low. irq is high whenever the code is not 0x01.
- R10: bus_rdata and bus_err are registered and valid in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address, index in bits 4:2 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Registered pulse for an illegal access |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Incoming byte present |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | High while no byte is held |
| lerr_parity | input | 1 | Parity error pulse |
| lerr_frame | input | 1 | Framing error pulse |
| lerr_break | input | 1 | Break pulse |
| tx_hold_empty | input | 1 | Holding register empty level |
| tx_shift_empty | input | 1 | Shifter empty level |
| modem_stat | input | 8 | Modem status levels and deltas |
| line_cfg | output | 8 | Stored line configuration |
| modem_cfg | output | 2 | Stored modem control |
| baud_div | output | DIV_W | Stored divisor |
| irq | output | 1 | Interrupt request level |

## Verification
Two pairs of functions can act in the same cycle. A data-register read can coincide with an incoming byte, and a status read can coincide with an error pulse. The bench drives both in one cycle. In the first case it expects the old byte on the read data, with data-ready still set, overrun clear and the new byte returned by the next read. In the second case the read returns the flags as they were before that cycle, and a second status read shows the new error still present.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
   localparam int IDX_W  = 3;
   localparam int BYTE_W = 8;

   typedef enum logic [IDX_W-1:0] {
      IDX_DATA = 3'd0,
      IDX_IEN  = 3'd1,
      IDX_IID  = 3'd2,
      IDX_LCFG = 3'd3,
      IDX_MCFG = 3'd4,
      IDX_LST  = 3'd5,
      IDX_MST  = 3'd6,
      IDX_DIV  = 3'd7
   } reg_idx_t;

   typedef enum logic [2:0] {
      CAUSE_LINE = 3'b110,
      CAUSE_RXD  = 3'b100,
      CAUSE_THR  = 3'b010,
      CAUSE_MDM  = 3'b000,
      CAUSE_NONE = 3'b001
   } irq_cause_t;

   // sticky line-error flags, in status-register order above data-ready
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
      logic ovr;
   } line_err_t;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [BW-1:0] byte_in,
   input  logic          consume,
   output logic [BW-1:0] held,
   output logic          ready_n,
   output logic          ovr_evt
);
   logic [BW-1:0] held_q;
   logic          full_q;

   assign held    = held_q;
   assign ready_n = full_q;
   assign ovr_evt = take & full_q & ~consume;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         full_q <= 1'b0;
      end else if (take) begin
         held_q <= byte_in;
         full_q <= 1'b1;
      end else if (consume) begin
         full_q <= 1'b0;
      end
   end

   // R5
   take_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ready_n && held == $past(byte_in)));
   // R5
   read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !take) |=> !ready_n);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_regs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] en,
   input  line_err_t  lerr,
   input  logic       dready,
   input  logic       thr_empty,
   input  logic [3:0] mdm_delta,
   output irq_cause_t cause,
   output logic       pend
);
   logic any_line, any_mdm;

   assign any_line = |lerr;
   assign any_mdm  = |mdm_delta;

   always_comb begin
      if (any_line && en[2])       cause = CAUSE_LINE;
      else if (dready && en[0])    cause = CAUSE_RXD;
      else if (thr_empty && en[1]) cause = CAUSE_THR;
      else if (any_mdm && en[3])   cause = CAUSE_MDM;
      else                         cause = CAUSE_NONE;
   end

   assign pend = (any_line & en[2]) | (dready & en[0]) |
                 (thr_empty & en[1]) | (any_mdm & en[3]);

   // R9
   line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_line && en[2]) |-> cause == CAUSE_LINE);
   // R9
   pend_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend != (cause == CAUSE_NONE));
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
   import uart_regs_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              tx_strobe,
   output logic [7:0]        tx_byte,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              rx_ready,
   input  logic              lerr_parity,
   input  logic              lerr_frame,
   input  logic              lerr_break,
   input  logic              tx_hold_empty,
   input  logic              tx_shift_empty,
   input  logic [7:0]        modem_stat,
   output logic [7:0]        line_cfg,
   output logic [1:0]        modem_cfg,
   output logic [DIV_W-1:0]  baud_div,
   output logic              irq
);
   localparam int IDX_LSB = 2;
   localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

   if (ADDR_W < IDX_MSB + 1) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end
   if (DATA_W < DIV_W || DATA_W < BYTE_W) begin : g_bad_data
      $error("DATA_W narrower than a stored field");
   end

   reg_idx_t          idx;
   logic              is_wo, is_ro, illegal, rd_ok, wr_ok;
   logic              data_rd, data_wr, lst_rd;
   logic [3:0]        ien_q;
   logic [7:0]        lcfg_q;
   logic [1:0]        mcfg_q;
   logic [DIV_W-1:0]  div_q;
   line_err_t         lerr_q, lerr_set;
   logic              thre_q, temt_q;
   logic [7:0]        mst_q;
   logic [DATA_W-1:0] rdata_q, rd_mux;
   logic              berr_q, txv_q;
   logic [7:0]        txb_q;
   logic [7:0]        held;
   logic              full, ovr_evt;
   logic [7:0]        lst_val;
   irq_cause_t        cause;
   logic              pend;

   assign idx     = reg_idx_t'(bus_addr[IDX_MSB:IDX_LSB]);
   assign is_wo   = (idx == IDX_IEN) || (idx == IDX_LCFG) ||
                    (idx == IDX_MCFG) || (idx == IDX_DIV);
   assign is_ro   = (idx == IDX_IID) || (idx == IDX_LST) || (idx == IDX_MST);
   assign illegal = bus_sel && (bus_we ? is_ro : is_wo);
   assign rd_ok   = bus_sel && !bus_we && !is_wo;
   assign wr_ok   = bus_sel && bus_we && !is_ro;
   assign data_rd = rd_ok && (idx == IDX_DATA);
   assign data_wr = wr_ok && (idx == IDX_DATA);
   assign lst_rd  = rd_ok && (idx == IDX_LST);

   uart_rx_hold #(.BW(BYTE_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (rx_valid),
      .byte_in (rx_byte),
      .consume (data_rd),
      .held    (held),
      .ready_n (full),
      .ovr_evt (ovr_evt)
   );
   assign rx_ready = ~full;

   uart_irq_prio u_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ien_q),
      .lerr      (lerr_q),
      .dready    (full),
      .thr_empty (thre_q),
      .mdm_delta (mst_q[3:0]),
      .cause     (cause),
      .pend      (pend)
   );

   assign lst_val  = {1'b0, temt_q, thre_q, lerr_q, full};
   assign lerr_set = '{brk: lerr_break, frm: lerr_frame,
                       par: lerr_parity, ovr: ovr_evt};

   always_comb begin
      rd_mux = '0;
      if (rd_ok) begin
         unique case (idx)
            IDX_DATA: rd_mux[7:0] = held;
            IDX_IID:  rd_mux[2:0] = cause;
            IDX_LST:  rd_mux[7:0] = lst_val;
            IDX_MST:  rd_mux[7:0] = mst_q;
            default:  rd_mux      = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= '0;
         lcfg_q  <= '0;
         mcfg_q  <= '0;
         div_q   <= '0;
         lerr_q  <= '0;
         thre_q  <= 1'b1;
         temt_q  <= 1'b1;
         mst_q   <= '0;
         rdata_q <= '0;
         berr_q  <= 1'b0;
         txv_q   <= 1'b0;
         txb_q   <= '0;
      end else begin
         if (wr_ok && idx == IDX_IEN)  ien_q  <= bus_wdata[3:0];
         if (wr_ok && idx == IDX_LCFG) lcfg_q <= bus_wdata[7:0];
         if (wr_ok && idx == IDX_MCFG) mcfg_q <= bus_wdata[1:0];
         if (wr_ok && idx == IDX_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
         lerr_q  <= (lst_rd ? line_err_t'('0) : lerr_q) | lerr_set;
         thre_q  <= tx_hold_empty;
         temt_q  <= tx_shift_empty;
         mst_q   <= modem_stat;
         rdata_q <= rd_mux;
         berr_q  <= illegal;
         txv_q   <= data_wr;
         if (data_wr) txb_q <= bus_wdata[7:0];
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = pend;
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = berr_q;
   assign tx_strobe = txv_q;
   assign tx_byte   = txb_q;
   assign line_cfg  = lcfg_q;
   assign modem_cfg = mcfg_q;
   assign baud_div  = div_q;

   // R4
   tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && idx == IDX_DATA) |=>
      (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !data_rd) |=> lerr_q.ovr);
   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lerr_q.par && !lst_rd) |=> lerr_q.par);
   // R10
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_sel));
   // R3
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && is_ro) |=> ($stable(ien_q) && bus_err));
endmodule

// File: tb/tb_uart_regblk.sv
`timescale 1ns/1ps
module tb_uart_regblk;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_we;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        bus_err, tx_strobe, rx_valid, rx_ready;
   logic [7:0]  tx_byte, rx_byte, modem_stat, line_cfg;
   logic        lerr_parity, lerr_frame, lerr_break;
   logic        tx_hold_empty, tx_shift_empty, irq;
   logic [1:0]  modem_cfg;
   logic [15:0] baud_div;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] rd_q[$];
   string       rd_tag[$];
   logic [7:0]  tx_q[$];

   always #2.5 clk = ~clk;

   uart_regblk dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
      .lerr_parity(lerr_parity), .lerr_frame(lerr_frame),
      .lerr_break(lerr_break), .tx_hold_empty(tx_hold_empty),
      .tx_shift_empty(tx_shift_empty), .modem_stat(modem_stat),
      .line_cfg(line_cfg), .modem_cfg(modem_cfg), .baud_div(baud_div),
      .irq(irq)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: read data and transmit bytes
   always @(negedge clk) begin
      if (rd_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = rd_q.pop_front();
         t = rd_tag.pop_front();
         chk(bus_rdata === e, t, bus_rdata, e);
      end
      if (tx_strobe === 1'b1) begin
         if (tx_q.size() == 0) chk(1'b0, "R4 unexpected tx", tx_byte, 0);
         else begin
            logic [7:0] b;
            b = tx_q.pop_front();
            chk(tx_byte === b, "R4 tx byte", tx_byte, b);
         end
      end
   end

   // one bus access; optional receive byte and framing pulse in the same cycle
   task automatic bus(input logic we, input logic [4:0] a,
                      input logic [31:0] wd, input logic [31:0] exp_rd,
                      input logic exp_err, input string tag,
                      input logic rxv = 1'b0, input logic [7:0] rxb = 8'h0,
                      input logic frm = 1'b0);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
      rx_valid = rxv; rx_byte = rxb; lerr_frame = frm;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0; lerr_frame = 1'b0;
      if (!we) begin
         rd_q.push_back(exp_rd);
         rd_tag.push_back(tag);
      end else if (a[4:2] == 3'd0) begin
         tx_q.push_back(wd[7:0]);
      end
      chk(bus_err === exp_err, {tag, " bus_err (R10)"}, bus_err, exp_err);
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(posedge clk);
      #1 rx_valid = 1'b0;
   endtask

   task automatic par_pulse();
      @(negedge clk);
      lerr_parity = 1'b1;
      @(posedge clk);
      #1 lerr_parity = 1'b0;
   endtask

   task automatic set_levels(input logic thre, input logic [7:0] ms);
      @(negedge clk);
      tx_hold_empty = thre; modem_stat = ms;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
      bus_wdata = '0; rx_valid = 1'b0; rx_byte = '0;
      lerr_parity = 1'b0; lerr_frame = 1'b0; lerr_break = 1'b0;
      tx_hold_empty = 1'b1; tx_shift_empty = 1'b1; modem_stat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(irq === 1'b0, "R1 irq", irq, 0);
      chk(rx_ready === 1'b1, "R1 rx_ready", rx_ready, 1);
      chk({line_cfg, modem_cfg, baud_div} === '0, "R1 cfg", line_cfg, 0);
      chk(tx_strobe === 1'b0, "R1 tx_strobe", tx_strobe, 0);
      bus(0, 5'h14, 0, 32'h60, 0, "R1 status");
      bus(0, 5'h08, 0, 32'h01, 0, "R1 ident");

      // R2
      bus(1, 5'h0C, 32'h1B, 0, 0, "R2 lcfg wr");
      bus(1, 5'h10, 32'h3, 0, 0, "R2 mcfg wr");
      bus(1, 5'h1C, 32'h1234, 0, 0, "R2 div wr");
      chk(line_cfg === 8'h1B, "R2 line_cfg", line_cfg, 8'h1B);
      chk(modem_cfg === 2'h3, "R2 modem_cfg", modem_cfg, 3);
      chk(baud_div === 16'h1234, "R2 baud_div", baud_div, 16'h1234);
      bus(0, 5'h0C, 0, 32'h0, 1, "R2 lcfg rd");
      bus(0, 5'h1C, 0, 32'h0, 1, "R2 div rd");

      // R3
      bus(1, 5'h08, 32'hFF, 0, 1, "R3 ident wr");
      bus(1, 5'h14, 32'h1F, 0, 1, "R3 status wr");
      bus(1, 5'h18, 32'hFF, 0, 1, "R3 modem wr");
      bus(0, 5'h08, 0, 32'h01, 0, "R3 ident kept");
      bus(0, 5'h14, 0, 32'h60, 0, "R3 status kept");
      chk(irq === 1'b0, "R3 irq kept", irq, 0);

      // R4
      bus(1, 5'h00, 32'h1A5, 0, 0, "R4 tx");
      bus(1, 5'h00, 32'h03C, 0, 0, "R4 tx2");

      // R9 priority walk
      bus(1, 5'h04, 32'h2, 0, 0, "R9 ien thr");
      chk(irq === 1'b1, "R9 irq thr", irq, 1);
      bus(0, 5'h08, 0, 32'h02, 0, "R9 ident thr");
      bus(1, 5'h04, 32'hF, 0, 0, "R9 ien all");
      rx_push(8'h55);
      chk(rx_ready === 1'b0, "R5 ready low", rx_ready, 0);
      bus(0, 5'h08, 0, 32'h04, 0, "R9 ident rxd");
      par_pulse();
      bus(0, 5'h08, 0, 32'h06, 0, "R9 ident line");
      bus(0, 5'h14, 0, 32'h65, 0, "R7 status par");
      bus(0, 5'h08, 0, 32'h04, 0, "R7 cleared ident");
      bus(0, 5'h00, 0, 32'h55, 0, "R5 data rd");
      chk(rx_ready === 1'b1, "R5 ready high", rx_ready, 1);
      bus(0, 5'h08, 0, 32'h02, 0, "R9 ident thr2");
      set_levels(1'b0, 8'h00);
      chk(irq === 1'b0, "R8 R9 thre drop irq", irq, 0);
      bus(0, 5'h08, 0, 32'h01, 0, "R9 ident none");
      set_levels(1'b0, 8'h08);
      chk(irq === 1'b1, "R9 irq mdm", irq, 1);
      bus(0, 5'h08, 0, 32'h00, 0, "R9 ident mdm");
      bus(0, 5'h18, 0, 32'h08, 0, "R8 modem rd");
      set_levels(1'b0, 8'h10);
      chk(irq === 1'b0, "R9 no delta irq", irq, 0);
      bus(0, 5'h18, 0, 32'h10, 0, "R8 modem rd2");

      // R6 overrun
      rx_push(8'h11);
      rx_push(8'h22);
      bus(0, 5'h08, 0, 32'h06, 0, "R6 ident ovr");
      bus(0, 5'h14, 0, 32'h43, 0, "R6 status ovr");
      bus(0, 5'h00, 0, 32'h22, 0, "R6 newest byte");
      bus(0, 5'h14, 0, 32'h40, 0, "R6 status clear");

      // R6 same-cycle data read and arrival
      rx_push(8'h33);
      bus(0, 5'h00, 0, 32'h33, 0, "R6 read+rx old", 1'b1, 8'h44);
      bus(0, 5'h14, 0, 32'h41, 0, "R6 no ovr");
      bus(0, 5'h00, 0, 32'h44, 0, "R6 new byte");

      // R7 same-cycle status read and framing pulse
      bus(0, 5'h14, 0, 32'h40, 0, "R7 rd+frm", 1'b0, 8'h0, 1'b1);
      bus(0, 5'h14, 0, 32'h48, 0, "R7 frm kept");
      bus(0, 5'h14, 0, 32'h40, 0, "R7 frm cleared");

      bus(1, 5'h04, 32'h0, 0, 0, "R9 ien off");
      chk(irq === 1'b0, "R9 irq off", irq, 0);
      repeat (3) @(negedge clk);
      chk(rd_q.size() == 0 && tx_q.size() == 0, "R4 R10 queues drained",
          rd_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule